// File: doc/BRIEF.md
# Instruction Prefetch Pipe with Long-Word Holding Register

This block keeps a short queue of 16-bit instruction words ready for a decoder. A sequencer asks for one word at a time by word address through a valid/ready handshake. Every word reaches the pipe through a 32-bit holding register. A request for the even word of an aligned long word always fetches the whole long word from memory. The upper half goes into the entry stage, and the full long word stays in the holding register. A later request for the odd word of that same long word is served from the low half of the holding register, and memory is not touched. If the holding register does not hold that long word, the odd request also fetches.

The pipe has three stages: entry, middle and decode. Each accepted word enters the entry stage while the older words move one place toward the decode stage. Only the decode stage drives the decode outputs. Every stage also carries a fault bit. The bit is set when the word came from a memory response that reported an error, and it moves with the word. The pipe changes only when a word is loaded. It does not fill itself, and it holds still while a fetch is outstanding.

A flush input empties all three stages and invalidates the holding register in one cycle, for use on branches and exceptions. If a fetch is in flight when the flush arrives, its response is still awaited and then thrown away.

Top module: `prefetch_pipe`

## Requirements
- R1: After reset the decode stage is empty (dec_valid=0, dec_fault=0), req_ready=1 and mem_req_valid=0.
- R2: req_ready is 1 only when no fetch is outstanding or being drained and flush is 0. From the cycle after a memory request until the cycle of its response, req_ready is 0.
- R3: On the response to an even-word request (req_addr bit 0 = 0), bits 31:16 of mem_rsp_data enter the entry stage at that clock edge, and the long word is kept in the holding register.
- R4: An odd-word request (req_addr bit 0 = 1) whose long-word address (req_addr >> 1) matches a valid holding register is accepted without a memory request. Bits 15:0 of the held long word enter the entry stage at the next edge.
- R5: Every even request, and every odd request that misses the holding register, raises mem_req_valid for exactly its acceptance cycle with mem_req_addr = req_addr >> 1. On the response to an odd miss, bits 15:0 of the data are loaded.
- R6: Each load moves the entry word to the middle stage and the middle word to the decode stage. dec_valid/dec_word show the decode stage, so a word appears at the decode outputs after the third load that includes it.
- R7: A response with mem_rsp_err=1 sets the fault bit of the loaded word. An odd-word hit on that held long word is also marked faulty. The bit travels with the word to dec_fault.
- R8: Without a load the three stages keep their contents, including every cycle a fetch is outstanding.
- R9: flush=1 clears all stage valid and fault bits and the holding-register valid flag at the next edge. No request is accepted in a flush cycle, and a following odd request issues a memory fetch.
- R10: A flush during an outstanding fetch discards that fetch's response. Nothing is loaded, req_ready stays 0 until that response arrives, and it returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the pipe and invalidate the holding register |
| req_valid | input | 1 | Prefetch request present |
| req_addr | input | AW | Word address of the requested instruction word |
| req_ready | output | 1 | Prefetch request can be taken this cycle |
| mem_req_valid | output | 1 | Long-word fetch issued this cycle |
| mem_req_addr | output | AW-1 | Long-word address of the fetch |
| mem_rsp_valid | input | 1 | Response to the outstanding fetch |
| mem_rsp_data | input | 32 | Fetched long word |
| mem_rsp_err | input | 1 | Fetch ended abnormally |
| dec_valid | output | 1 | Decode stage holds a word |
| dec_word | output | 16 | Word in the decode stage |
| dec_fault | output | 1 | Decode-stage word came from a failed fetch |

## Verification
The hardest case to reach is a flush that lands while a fetch is outstanding. The response then arrives during the drain state and must be dropped. A flush exactly in the response cycle is harder still. The stimulus reaches both cases in two ways. A directed sequence issues an even request, flushes one cycle later, and holds the memory response back for several cycles. A long random phase then mixes flush pulses with memory latencies of one to four cycles, so flushes fall on every cycle of a fetch, the response cycle included. Faulty long words sit at fixed addresses, so their odd-word hits carry the fault bit through the pipe.

// File: rtl/prefetch_pipe_pkg.sv
package prefetch_pipe_pkg;

  // Width of one instruction word and of the long word that holds two.
  localparam int WORD_W = 16;
  localparam int LONG_W = 2 * WORD_W;

  // Fetch controller states.
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_WAIT  = 2'd1,
    FS_DRAIN = 2'd2
  } fetch_state_e;

  // One pipe stage: valid flag, fault flag and the word itself.
  typedef struct packed {
    logic              vld;
    logic              flt;
    logic [WORD_W-1:0] word;
  } stage_t;

  // Select the word of a long word: odd picks the low half.
  function automatic logic [WORD_W-1:0] pick_half(input logic [LONG_W-1:0] lw,
                                                  input logic odd);
    return odd ? lw[WORD_W-1:0] : lw[LONG_W-1:WORD_W];
  endfunction

  // An empty stage.
  function automatic stage_t empty_stage();
    stage_t s;
    s.vld  = 1'b0;
    s.flt  = 1'b0;
    s.word = '0;
    return s;
  endfunction

endpackage

// File: rtl/prefetch_pipe_hold.sv
module prefetch_pipe_hold
  import prefetch_pipe_pkg::*;
#(
  parameter int LA_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [LA_W-1:0]   load_la,
  input  logic [LONG_W-1:0] load_data,
  input  logic              load_err,
  input  logic [LA_W-1:0]   probe_la,
  output logic              hit,
  output logic [WORD_W-1:0] low_word,
  output logic              held_fault
);

  logic              held_vld;
  logic [LA_W-1:0]   held_la;
  logic [LONG_W-1:0] held_data;
  logic              held_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_la   <= '0;
      held_data <= '0;
      held_err  <= 1'b0;
    end else if (clear) begin
      held_vld <= 1'b0;
      held_err <= 1'b0;
    end else if (load) begin
      held_vld  <= 1'b1;
      held_la   <= load_la;
      held_data <= load_data;
      held_err  <= load_err;
    end
  end

  // The odd word can come from here only if the same long word is held.
  assign hit        = held_vld && (held_la == probe_la);
  assign low_word   = pick_half(held_data, 1'b1);
  assign held_fault = held_err;

endmodule

// File: rtl/prefetch_pipe_ctrl.sv
module prefetch_pipe_ctrl
  import prefetch_pipe_pkg::*;
#(
  parameter int AW = 16,
  localparam int LA_W = AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              req_ready,
  input  logic              hold_hit,
  output logic              mem_req_valid,
  output logic [LA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              hit_take,
  output logic              rsp_take,
  output logic [LA_W-1:0]   pend_la,
  output logic              pend_odd
);

  fetch_state_e state, state_nx;

  logic            accept;
  logic            req_odd;
  logic            need_fetch;
  logic [LA_W-1:0] req_la;

  assign req_odd    = req_addr[0];
  assign req_la     = req_addr[AW-1:1];
  assign req_ready  = (state == FS_IDLE) && !flush;
  assign accept     = req_valid && req_ready;
  assign need_fetch = !req_odd || !hold_hit;

  assign mem_req_valid = accept && need_fetch;
  assign mem_req_addr  = req_la;
  assign hit_take      = accept && !need_fetch;
  assign rsp_take      = (state == FS_WAIT) && mem_rsp_valid && !flush;

  always_comb begin
    state_nx = state;
    unique case (state)
      FS_IDLE: begin
        if (mem_req_valid) state_nx = FS_WAIT;
      end
      FS_WAIT: begin
        if (mem_rsp_valid)  state_nx = FS_IDLE;
        else if (flush)     state_nx = FS_DRAIN;
      end
      FS_DRAIN: begin
        if (mem_rsp_valid)  state_nx = FS_IDLE;
      end
      default: state_nx = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      pend_la  <= '0;
      pend_odd <= 1'b0;
    end else begin
      state <= state_nx;
      if (mem_req_valid) begin
        pend_la  <= req_la;
        pend_odd <= req_odd;
      end
    end
  end

endmodule

// File: rtl/prefetch_pipe_stages.sv
module prefetch_pipe_stages
  import prefetch_pipe_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   shift,
  input  stage_t in_word,
  output stage_t out_word
);

  stage_t stq [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    stage_t nx;
    if (i == 0) begin : g_entry
      assign nx = in_word;
    end else begin : g_follow
      assign nx = stq[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        stq[i] <= empty_stage();
      end else if (shift) begin
        stq[i] <= nx;
      end
    end
  end

  assign out_word = stq[STAGES-1];

endmodule

// File: rtl/prefetch_pipe.sv
module prefetch_pipe
  import prefetch_pipe_pkg::*;
#(
  parameter int AW     = 16,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              req_ready,
  output logic              mem_req_valid,
  output logic [AW-2:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LONG_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              dec_valid,
  output logic [WORD_W-1:0] dec_word,
  output logic              dec_fault
);

  localparam int LA_W = AW - 1;

  // Named internal events, visible to the bound checker.
  logic              hold_hit;
  logic              hit_take;
  logic              rsp_take;
  logic              load_evt;
  logic [LA_W-1:0]   pend_la;
  logic              pend_odd;
  logic [WORD_W-1:0] held_low;
  logic              held_fault;
  stage_t            entry_word;
  stage_t            last_word;

  prefetch_pipe_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .hold_hit      (hold_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .hit_take      (hit_take),
    .rsp_take      (rsp_take),
    .pend_la       (pend_la),
    .pend_odd      (pend_odd)
  );

  prefetch_pipe_hold #(.LA_W(LA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (flush),
    .load       (rsp_take),
    .load_la    (pend_la),
    .load_data  (mem_rsp_data),
    .load_err   (mem_rsp_err),
    .probe_la   (req_addr[AW-1:1]),
    .hit        (hold_hit),
    .low_word   (held_low),
    .held_fault (held_fault)
  );

  // Every word reaches the pipe through the holding register path: either
  // the word just captured from memory or the low half kept from earlier.
  always_comb begin
    entry_word.vld = 1'b1;
    if (rsp_take) begin
      entry_word.word = pick_half(mem_rsp_data, pend_odd);
      entry_word.flt  = mem_rsp_err;
    end else begin
      entry_word.word = held_low;
      entry_word.flt  = held_fault;
    end
  end

  assign load_evt = hit_take || rsp_take;

  prefetch_pipe_stages #(.STAGES(STAGES)) u_stages (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush),
    .shift    (load_evt),
    .in_word  (entry_word),
    .out_word (last_word)
  );

  assign dec_valid = last_word.vld;
  assign dec_word  = last_word.word;
  assign dec_fault = last_word.flt;

endmodule

// File: rtl/prefetch_pipe_chk.sv
module prefetch_pipe_chk
  import prefetch_pipe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic              hit_take,
  input logic              load_evt,
  input logic              dec_valid,
  input logic [WORD_W-1:0] dec_word,
  input logic              dec_fault
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !dec_valid && req_ready == !flush && !mem_req_valid);

  assert_ready_after_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !req_ready);

  assert_fetch_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> req_valid && req_ready);

  assert_hit_no_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_take |-> !mem_req_valid);

  assert_fault_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fault |-> dec_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt && !flush |=> $stable(dec_valid) && $stable(dec_word) && $stable(dec_fault));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dec_valid && !dec_fault);

  assert_flush_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready && !load_evt);

  assert_drain_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !mem_rsp_valid && !req_ready |=> !load_evt);

endmodule

bind prefetch_pipe prefetch_pipe_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .hit_take      (hit_take),
  .load_evt      (load_evt),
  .dec_valid     (dec_valid),
  .dec_word      (dec_word),
  .dec_fault     (dec_fault)
);

// File: tb/prefetch_pipe_test.sv
module prefetch_pipe_test;

  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [14:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        dec_valid;
  logic [15:0] dec_word;
  logic        dec_fault;

  prefetch_pipe #(.AW(AW), .STAGES(3)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err),
    .dec_valid(dec_valid), .dec_word(dec_word), .dec_fault(dec_fault)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural model: stage arrays, holding-register record, fetch phase.
  bit          mv[3];
  bit          mf[3];
  int          mw[3];
  bit          h_vld;
  int          h_la;
  logic [31:0] h_data;
  bit          h_err;
  int          phase;      // 0 free, 1 waiting for data, 2 draining
  int          p_la;
  bit          p_odd;
  bit          last_acc;

  // Memory responder: at most one fetch outstanding.
  int mem_q[$];
  int mem_lat;
  int lat_pick = 2;

  function automatic logic [31:0] mem_word(int la);
    logic [15:0] a = la[15:0];
    return {a ^ 16'h5A00, a + 16'h1234};
  endfunction

  function automatic bit mem_bad(int la);
    return (la % 8) == 5;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      mv[i] = 0; mf[i] = 0; mw[i] = 0;
    end
  endtask

  task automatic model_load(int w, bit f);
    mv[2] = mv[1]; mf[2] = mf[1]; mw[2] = mw[1];
    mv[1] = mv[0]; mf[1] = mf[0]; mw[1] = mw[0];
    mv[0] = 1;     mf[0] = f;     mw[0] = w;
  endtask

  // One clock: drive, compare against the model, advance the model.
  task automatic cycle(bit fl, bit rv, int ra);
    bit rsp;
    bit rdy;
    bit hit;
    bit fetch;
    int rla;
    logic [31:0] rd;
    bit re;
    @(negedge clk);
    flush = fl; req_valid = rv; req_addr = ra[15:0];
    rsp = (mem_q.size() > 0) && (mem_lat == 0);
    rla = rsp ? mem_q[0] : 0;
    rd  = mem_word(rla);
    re  = mem_bad(rla);
    mem_rsp_valid = rsp; mem_rsp_data = rsp ? rd : 32'h0; mem_rsp_err = rsp && re;
    #1;
    rdy   = (phase == 0) && !fl;
    hit   = h_vld && (h_la == (ra >> 1));
    fetch = rdy && rv && (!ra[0] || !hit);
    last_acc = rdy && rv;
    check("R2 req_ready", req_ready, rdy);
    check("R4 mem_req_valid", mem_req_valid, fetch);
    if (fetch) check("R5 mem_req_addr", mem_req_addr, (ra >> 1) & 16'h7FFF);
    check("R6 dec_valid", dec_valid, mv[2]);
    if (mv[2]) check("R3 dec_word", dec_word, mw[2]);
    check("R7 dec_fault", dec_fault, mf[2]);
    // memory bookkeeping
    if (rsp) void'(mem_q.pop_front());
    if (fetch) begin
      mem_q.push_back(ra >> 1);
      mem_lat = lat_pick;
    end else if (mem_q.size() > 0 && mem_lat > 0) begin
      mem_lat--;
    end
    // model state step
    if (fl) begin
      model_clear();
      h_vld = 0;
      if (phase != 0) phase = rsp ? 0 : 2;
    end else begin
      case (phase)
        0: if (rdy && rv) begin
             if (fetch) begin phase = 1; p_la = ra >> 1; p_odd = ra[0]; end
             else model_load(int'(h_data[15:0]), h_err);
           end
        1: if (rsp) begin
             h_vld = 1; h_la = p_la; h_data = rd; h_err = re;
             model_load(p_odd ? int'(rd[15:0]) : int'(rd[31:16]), re);
             phase = 0;
           end
        default: if (rsp) phase = 0;
      endcase
    end
  endtask

  // Issue one request and hold it until accepted.
  task automatic request(int ra);
    int n = 0;
    do begin
      cycle(0, 1, ra);
      n++;
    end while (!last_acc && n < 50);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0);
  endtask

  initial begin
    int cur;
    int held_word;
    model_clear();
    h_vld = 0; h_la = 0; h_data = '0; h_err = 0; phase = 0; mem_lat = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 dec_valid", dec_valid, 0);
    check("R1 dec_fault", dec_fault, 0);
    check("R1 req_ready", req_ready, 1);
    check("R1 mem_req_valid", mem_req_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sequential stream: even fetches, odd hits.
    for (int a = 16'h100; a < 16'h114; a++) request(a);
    idle(4);

    // Odd miss at a fresh long word, then its neighbours (includes faulty la).
    request(16'h0209);
    request(16'h020A);
    request(16'h020B);
    request(16'h020B);
    idle(4);

    // Stall: long latency, outputs must not move during the wait.
    lat_pick = 4;
    request(16'h0300);
    held_word = dec_word;
    cycle(0, 0, 0);
    check("R8 stall dec_word", dec_word, held_word);
    idle(6);
    lat_pick = 2;

    // Flush in idle: pipe empties, next odd of the held long word misses.
    request(16'h0400);
    idle(4);
    cycle(1, 1, 16'h0401);
    cycle(0, 0, 0);
    check("R9 empty after flush", dec_valid, 0);
    cycle(0, 1, 16'h0401);
    check("R9 odd after flush fetches", mem_req_valid, 1);
    idle(5);

    // Flush during an outstanding fetch: response must be dropped.
    lat_pick = 4;
    request(16'h0500);
    cycle(1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      cycle(0, 1, 16'h0600);
      check("R10 ready low while draining", req_ready, 0);
    end
    cycle(0, 0, 0);
    check("R10 ready back", req_ready, 1);
    check("R10 nothing loaded", dec_valid, 0);
    lat_pick = 2;
    idle(2);

    // Random phase.
    cur = 16'h0700;
    for (int i = 0; i < 4000; i++) begin
      bit fl = ($urandom_range(0, 99) < 4);
      bit rv = ($urandom_range(0, 99) < 80);
      lat_pick = $urandom_range(1, 4);
      cycle(fl, rv, cur);
      if (last_acc) begin
        if ($urandom_range(0, 9) == 0) cur = $urandom_range(0, 16'hFFFF);
        else cur = (cur + 1) & 16'hFFFF;
      end
    end
    idle(8);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule